// File: doc/BRIEF.md
# Layer Word-Line Budget Selector

This block decides, for one neural-network layer at a time, how many word lines a resistive compute array may drive together. Driving more rows finishes a layer in fewer array cycles. Driving more rows also adds more leakage current from cells in the high-resistance state, and that current corrupts the accumulated sum. The block weighs the layer's exposure to this error as a small signed risk score. A higher score selects a smaller row count.

The score is built from four terms:
- the layer kind: a convolution adds one, a fully connected layer subtracts one;
- the share of zeros in the most significant weight bit plane;
- the cell on/off resistance ratio;
- a logarithmic penalty on the number of weight-matrix rows, above a selectable threshold.

A programmable table turns the score into a power-of-two exponent. The resulting count is capped at the physical array height. It is also reduced to the smallest power of two that still covers the layer's own rows.

A one-cycle load strobe captures the layer descriptor. The score and count are registered one cycle later, with a one-cycle done pulse, and both stay unchanged until the next load.

Top module: `wl_budget_top`

## Requirements
- R1: A `load` sampled high at clock edge k captures all descriptor inputs. `done` is high for exactly the cycle after edge k+1, when `risk_index` and `wl_count` show the new result. Without a load, input changes leave the outputs unchanged.
- R2: The layer kind adds +1 to the score when `layer_is_fc`=0 (convolution) and −1 when `layer_is_fc`=1.
- R3: A `msb_zero_pct` of 55 or more adds +1 to the score; 54 or less adds nothing.
- R4: An `onoff_ratio` of 10 or less adds +1, a ratio of 20 or more adds −1, and ratios from 11 to 19 add nothing.
- R5: With `deep_thr_sel`=0, a row count of 256 or more adds floor(log2(rows))−7. For example, 800 rows adds 2 and 300 rows adds 1.
- R6: With `deep_thr_sel`=1, only a row count of 512 or more adds a term, equal to floor(log2(rows))−8. Rows from 256 to 511 add nothing.
- R7: Table entry e holds the exponent for score e−2 (scores −2 to 4). The count is 2^exponent. After reset, the exponents for scores −2…4 are 9,8,7,6,5,4,4, so scores 3 and 4 both give 16.
- R8: A score above 4 uses entry 6, and a score below −2 uses entry 0.
- R9: When the layer has fewer rows than the mapped count, the count becomes the smallest power of two that is at least the row count. For example, 27 rows gives 32. A row count of 0 or 1 gives 1.
- R10: A table write (`tbl_we`=1, entry `tbl_addr` 0..6, exponent `tbl_code`) takes effect for later loads. An exponent above 9 yields 512, the array height. Address 7 changes nothing.
- R11: After reset, `done`=0, `risk_index`=0 and `wl_count`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Captures the layer descriptor |
| layer_is_fc | input | 1 | 1 = fully connected, 0 = convolution |
| row_count | input | 10 | Weight-matrix rows of the layer |
| msb_zero_pct | input | 7 | Percent of zero bits in the weight MSB plane |
| onoff_ratio | input | 8 | Cell high/low resistance ratio |
| deep_thr_sel | input | 1 | 0 = row penalty from 256 rows, 1 = from 512 rows |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 3 | Table entry to write |
| tbl_code | input | 4 | Exponent to store |
| done | output | 1 | One-cycle result strobe |
| risk_index | output | 4 | Signed risk score of the last layer |
| wl_count | output | 10 | Word lines to activate together (power of two) |

## Verification
The bench targets the edges of every score term:
- percentages 54 and 55;
- ratios 10, 11, 19 and 20;
- row counts of 255, 256, 511 and 512 under both threshold settings.

A design off by one at any of these edges shifts the score by one and picks the wrong row count. The bench drives a score of 5 to check that it saturates, rather than wrapping or indexing past the table. It drives 0, 1, 27 and 100 rows to check the cover rounding, where a truncating design would leave rows uncovered. It also writes oversized exponents to confirm the count never goes beyond 512. Finally, it changes inputs without a load, because a design that computes straight from the pins would let its outputs drift.

// File: rtl/wl_budget_pkg.sv
package wl_budget_pkg;
  localparam int ROW_W   = 10;
  localparam int PCT_W   = 7;
  localparam int RATIO_W = 8;
  localparam int CODE_W  = 4;
  localparam int IDX_W   = 4;
  localparam int POS_W   = $clog2(ROW_W + 1);

  typedef struct packed {
    logic               is_fc;
    logic               thr_hi;
    logic [ROW_W-1:0]   rows;
    logic [PCT_W-1:0]   zero_pct;
    logic [RATIO_W-1:0] ratio;
  } layer_desc_t;

  // default table exponent for a score: 7 - score, clamped to [lo, hi]
  function automatic int default_code(input int score, input int lo, input int hi);
    int c;
    c = 7 - score;
    if (c < lo) c = lo;
    if (c > hi) c = hi;
    return c;
  endfunction

  // lesser of two exponents
  function automatic int min_code(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/wl_lead_one.sv
module wl_lead_one #(
  parameter int W  = 10,
  parameter int PW = 4
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          any
);
  always_comb begin
    pos = '0;
    any = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos = PW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wl_risk_calc.sv
module wl_risk_calc
  import wl_budget_pkg::*;
#(
  parameter int ZERO_PCT_TH   = 55,
  parameter int RATIO_LO      = 10,
  parameter int RATIO_HI      = 20,
  parameter int ROW_BASE_LOG2 = 8
) (
  input  layer_desc_t              desc,
  input  logic [POS_W-1:0]         row_log2,
  input  logic                     row_nonzero,
  output logic signed [IDX_W-1:0]  score
);
  // named terms so each contribution can be observed on its own
  int term_kind, term_msb, term_ratio, term_rows, base_log2;

  always_comb begin
    term_kind  = desc.is_fc ? -1 : 1;
    term_msb   = (int'(desc.zero_pct) >= ZERO_PCT_TH) ? 1 : 0;
    if (int'(desc.ratio) <= RATIO_LO)      term_ratio = 1;
    else if (int'(desc.ratio) >= RATIO_HI) term_ratio = -1;
    else                                   term_ratio = 0;
    base_log2 = ROW_BASE_LOG2 + (desc.thr_hi ? 1 : 0);
    if (row_nonzero && int'(row_log2) >= base_log2)
      term_rows = int'(row_log2) - base_log2 + 1;
    else
      term_rows = 0;
  end

  assign score = IDX_W'(term_kind + term_msb + term_ratio + term_rows);
endmodule

// File: rtl/wl_code_table.sv
module wl_code_table
  import wl_budget_pkg::*;
#(
  parameter int IDX_MIN    = -2,
  parameter int IDX_MAX    = 4,
  parameter int FLOOR_CODE = 4,
  parameter int ARRAY_LOG2 = 9,
  localparam int N_ENTRY   = IDX_MAX - IDX_MIN + 1,
  localparam int ADDR_W    = $clog2(N_ENTRY)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [CODE_W-1:0]       wr_code,
  input  logic signed [IDX_W-1:0] score,
  output logic [CODE_W-1:0]       code
);
  logic [CODE_W-1:0] entry_q [N_ENTRY];
  int                sel;

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_entry
    localparam int RST_CODE = default_code(e + IDX_MIN, FLOOR_CODE, ARRAY_LOG2);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry_q[e] <= CODE_W'(RST_CODE);
      else if (wr_en && int'(wr_addr) == e)
        entry_q[e] <= wr_code;
    end
  end

  // saturating lookup: scores beyond either end use the end entries
  always_comb begin
    if (int'(score) > IDX_MAX)      sel = N_ENTRY - 1;
    else if (int'(score) < IDX_MIN) sel = 0;
    else                            sel = int'(score) - IDX_MIN;
    code = entry_q[sel];
  end
endmodule

// File: rtl/wl_budget_top.sv
module wl_budget_top
  import wl_budget_pkg::*;
#(
  parameter int ARRAY_LOG2    = 9,
  parameter int IDX_MIN       = -2,
  parameter int IDX_MAX       = 4,
  parameter int FLOOR_CODE    = 4,
  parameter int ZERO_PCT_TH   = 55,
  parameter int RATIO_LO      = 10,
  parameter int RATIO_HI      = 20,
  parameter int ROW_BASE_LOG2 = 8,
  localparam int N_ENTRY      = IDX_MAX - IDX_MIN + 1,
  localparam int ADDR_W       = $clog2(N_ENTRY),
  localparam int CNT_W        = ARRAY_LOG2 + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    layer_is_fc,
  input  logic [ROW_W-1:0]        row_count,
  input  logic [PCT_W-1:0]        msb_zero_pct,
  input  logic [RATIO_W-1:0]      onoff_ratio,
  input  logic                    deep_thr_sel,
  input  logic                    tbl_we,
  input  logic [ADDR_W-1:0]       tbl_addr,
  input  logic [CODE_W-1:0]       tbl_code,
  output logic                    done,
  output logic signed [IDX_W-1:0] risk_index,
  output logic [CNT_W-1:0]        wl_count
);
  layer_desc_t             desc_q;
  logic                    pend_q;
  logic [ROW_W-1:0]        held_rows;
  logic [ROW_W-1:0]        rows_m1;
  logic [POS_W-1:0]        row_log2, rows_m1_log2;
  logic                    row_nonzero, rows_m1_nz;
  logic signed [IDX_W-1:0] score_nxt;
  logic [CODE_W-1:0]       table_code;
  int                      cover_code, clamp_code, final_code;

  // stage 1: capture the descriptor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_q <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= load;
      if (load) begin
        desc_q.is_fc    <= layer_is_fc;
        desc_q.thr_hi   <= deep_thr_sel;
        desc_q.rows     <= row_count;
        desc_q.zero_pct <= msb_zero_pct;
        desc_q.ratio    <= onoff_ratio;
      end
    end
  end

  assign held_rows = desc_q.rows;
  assign rows_m1   = held_rows - ROW_W'(1);

  wl_lead_one #(.W(ROW_W), .PW(POS_W)) u_lod_rows (
    .vec(held_rows), .pos(row_log2), .any(row_nonzero)
  );

  wl_lead_one #(.W(ROW_W), .PW(POS_W)) u_lod_cover (
    .vec(rows_m1), .pos(rows_m1_log2), .any(rows_m1_nz)
  );

  wl_risk_calc #(
    .ZERO_PCT_TH(ZERO_PCT_TH), .RATIO_LO(RATIO_LO),
    .RATIO_HI(RATIO_HI), .ROW_BASE_LOG2(ROW_BASE_LOG2)
  ) u_risk (
    .desc(desc_q), .row_log2(row_log2), .row_nonzero(row_nonzero), .score(score_nxt)
  );

  wl_code_table #(
    .IDX_MIN(IDX_MIN), .IDX_MAX(IDX_MAX),
    .FLOOR_CODE(FLOOR_CODE), .ARRAY_LOG2(ARRAY_LOG2)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_addr(tbl_addr),
    .wr_code(tbl_code), .score(score_nxt), .code(table_code)
  );

  // cap: array height first, then the smallest cover of the layer rows
  always_comb begin
    if (int'(held_rows) <= 1 || !rows_m1_nz) cover_code = 0;
    else                                      cover_code = int'(rows_m1_log2) + 1;
    clamp_code = min_code(int'(table_code), ARRAY_LOG2);
    final_code = min_code(clamp_code, cover_code);
  end

  // stage 2: registered result and strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      risk_index <= '0;
      wl_count   <= CNT_W'(1);
    end else begin
      done <= pend_q;
      if (pend_q) begin
        risk_index <= score_nxt;
        wl_count   <= CNT_W'(1) << final_code;
      end
    end
  end
endmodule

// File: rtl/wl_budget_chk.sv
module wl_budget_chk
  import wl_budget_pkg::*;
#(
  parameter int ARRAY_LOG2 = 9,
  parameter int IDX_MIN    = -2,
  localparam int CNT_W     = ARRAY_LOG2 + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    load,
  input logic                    done,
  input logic signed [IDX_W-1:0] risk_index,
  input logic [CNT_W-1:0]        wl_count,
  input logic [ROW_W-1:0]        held_rows
);
  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ##2 done); // R1

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(load, 2)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(wl_count) && $stable(risk_index))); // R1

  AST_COUNT_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wl_count) == 1); // R7

  AST_COUNT_ARRAY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wl_count) <= (1 << ARRAY_LOG2)); // R10

  AST_COVER_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(load) && held_rows != 0 && int'(wl_count) > int'(held_rows))
      |-> (int'(wl_count) / 2) < int'(held_rows)); // R9

  AST_SCORE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int'(risk_index) >= IDX_MIN); // R2
endmodule

bind wl_budget_top wl_budget_chk #(.ARRAY_LOG2(ARRAY_LOG2), .IDX_MIN(IDX_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .done(done),
  .risk_index(risk_index), .wl_count(wl_count), .held_rows(held_rows)
);

// File: tb/wl_budget_top_tb.sv
module wl_budget_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic is_fc = 1'b0;
  logic [9:0] rows = '0;
  logic [6:0] pct = '0;
  logic [7:0] ratio = '0;
  logic thr = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] code = '0;
  logic done;
  logic signed [3:0] ridx;
  logic [9:0] cnt;

  int n_checks = 0;
  int n_errors = 0;
  int tbl [7];
  bit finished = 0;

  always #4 clk = ~clk;

  wl_budget_top u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .layer_is_fc(is_fc),
    .row_count(rows), .msb_zero_pct(pct), .onoff_ratio(ratio),
    .deep_thr_sel(thr), .tbl_we(we), .tbl_addr(addr), .tbl_code(code),
    .done(done), .risk_index(ridx), .wl_count(cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_score(bit f, int r, int p, int q, bit t);
    int s, lg, v;
    s = f ? -1 : 1;
    if (p >= 55) s += 1;
    if (q <= 10) s += 1;
    else if (q >= 20) s -= 1;
    lg = 0;
    v = r;
    while (v > 1) begin v = v / 2; lg++; end
    if (!t && r >= 256) s += lg - 7;
    if (t && r >= 512) s += lg - 8;
    return s;
  endfunction

  function automatic int model_count(int s, int r);
    int e, c, k, p;
    e = s;
    if (e > 4) e = 4;
    if (e < -2) e = -2;
    c = tbl[e + 2];
    if (c > 9) c = 9;
    k = 1;
    for (int i = 0; i < c; i++) k = k * 2;
    p = 1;
    while (p < r) p = p * 2;
    return (p < k) ? p : k;
  endfunction

  task automatic run(input string req, input bit f, input int r, input int p, input int q, input bit t);
    int es;
    @(negedge clk);
    is_fc = f; rows = 10'(r); pct = 7'(p); ratio = 8'(q); thr = t; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check({req, " done low mid"}, int'(done), 0);
    @(negedge clk);
    es = model_score(f, r, p, q, t);
    check({req, " R1 done"}, int'(done), 1);
    check({req, " score"}, int'(ridx), es);
    check({req, " count"}, int'(cnt), model_count(es, r));
  endtask

  task automatic wr(input int a, input int c);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); code = 4'(c);
    @(negedge clk);
    we = 1'b0;
    if (a < 7) tbl[a] = c;
  endtask

  initial begin
    for (int i = 0; i < 7; i++) begin
      tbl[i] = 7 - (i - 2);
      if (tbl[i] < 4) tbl[i] = 4;
      if (tbl[i] > 9) tbl[i] = 9;
    end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R11 done", int'(done), 0);
    check("R11 index", int'(ridx), 0);
    check("R11 count", int'(cnt), 1);
    rst_n = 1'b1;

    run("R8 R5 sat", 0, 800, 60, 10, 0);
    run("R9 cover27", 0, 27, 0, 30, 0);
    run("R6 R7 low", 1, 1000, 10, 25, 1);
    run("R9 rows0", 1, 0, 0, 50, 0);
    run("R9 rows1", 0, 1, 90, 5, 0);
    run("R3 pct54", 0, 600, 54, 15, 0);
    run("R3 pct55", 0, 600, 55, 15, 0);
    run("R4 ratio10", 1, 200, 0, 10, 0);
    run("R4 ratio11", 1, 200, 0, 11, 0);
    run("R4 ratio19", 1, 200, 0, 19, 0);
    run("R4 ratio20", 1, 200, 0, 20, 0);
    run("R5 rows255", 0, 255, 0, 15, 0);
    run("R5 rows256", 0, 256, 0, 15, 0);
    run("R6 rows511", 0, 511, 0, 15, 1);
    run("R6 rows512", 0, 512, 0, 15, 1);
    run("R2 conv", 0, 100, 0, 15, 0);
    run("R2 fc", 1, 100, 0, 15, 0);

    // R1: inputs move with no load, outputs must stay put
    begin
      int hold_c, hold_i;
      hold_c = int'(cnt); hold_i = int'(ridx);
      @(negedge clk);
      is_fc = ~is_fc; rows = 10'd900; pct = 7'd99; ratio = 8'd3; thr = ~thr;
      repeat (4) @(negedge clk);
      check("R1 hold count", int'(cnt), hold_c);
      check("R1 hold index", int'(ridx), hold_i);
      check("R1 no strobe", int'(done), 0);
    end

    // R10: oversize exponent clamps, address 7 ignored
    wr(0, 15);
    wr(7, 0);
    run("R10 clamp", 1, 1023, 0, 40, 1);
    wr(6, 12);
    run("R10 sat hi", 0, 1023, 80, 5, 0);

    for (int n = 0; n < 120; n++) begin
      if (n == 60) for (int e = 0; e < 7; e++) wr(e, int'($urandom_range(15, 0)));
      run("R7 random", 1'($urandom_range(1, 0)), int'($urandom_range(1023, 0)),
          int'($urandom_range(100, 0)), int'($urandom_range(60, 1)),
          1'($urandom_range(1, 0)));
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished == 1);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule